// File: doc/BRIEF.md
# Lock-Qualified Startup Reset Pulse Generator

This block produces a single, short, active-high reset pulse for a processor core, and fires it only after the clock generator feeding the core reports that its outputs are stable. A counter advances by one on each clock edge where the lock indicator is high. The pulse is decoded from a narrow, open-ended window of counter values. Once the counter reaches a stop value it freezes, so the pulse occurs exactly once per configuration.

With the default settings the block runs at 8 MHz, and the window opens 8,000,001 locked cycles in. The pulse therefore begins about one second after lock and lasts 19 cycles. An inverted copy of the pulse drives cores that take an active-low reset.

Lock is not assumed to be monotonic. While lock is low, the counter holds its value. When lock returns, counting resumes from the held value. The block has no reset input: its counter starts at zero from the configuration-time initial value.

Top module: `lockgate_rst_pulse`

## Requirements
- R1: The internal count rises by exactly one on each clock edge where `lock_i` is high, while it is below the stop value. The first pulse cycle therefore follows the (LO+1)-th locked edge, where LO is the window's lower bound.
- R2: Once the count reaches the stop value it stays there. No further pulse appears, whatever `lock_i` does.
- R3: `core_rst_o` is high exactly while the count is strictly greater than LO and strictly less than HI. Under continuous lock this gives a pulse of HI-LO-1 cycles.
- R4: `core_rst_n_o` is always the logical inverse of `core_rst_o`.
- R5: While `lock_i` has never been high, `core_rst_o` stays low (and `core_rst_n_o` high), for any number of cycles.
- R6: When `lock_i` is low, the count holds and the outputs hold their values. This applies inside the window too: a lock drop mid-pulse stretches the pulse by the length of the drop.
- R7: After configuration the count is zero, `core_rst_o` is low and `core_rst_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock (8 MHz with the default window) |
| lock_i | input | 1 | Lock indication from the clock generator, high when its outputs are stable |
| core_rst_o | output | 1 | Active-high startup reset pulse |
| core_rst_n_o | output | 1 | Active-low copy of the startup reset pulse |

## Verification
The hardest case to reach from the ports is a loss of lock while the pulse is already high. The counter is not observable, so the bench must know the exact cycle in which the count sits inside the window. The bench gets there by running a cycle-exact model of the locked-edge count in parallel with the design, using scaled window bounds (80, 100, stop 120). It first interrupts lock before the window to prove the count holds. It then drops lock ten cycles after the rising edge of the pulse and confirms that the pulse stays high for the whole gap and resumes for exactly its remaining locked cycles.

// File: rtl/lockgate_pkg.sv
package lockgate_pkg;

    // Default timing: 8 MHz clock, pulse roughly one second after lock
    localparam int unsigned DEF_CNT_W   = 24;
    localparam int unsigned DEF_WIN_LO  = 8_000_000;
    localparam int unsigned DEF_WIN_HI  = 8_000_020;
    localparam int unsigned DEF_STOP    = 9_000_000;

    // Phase of the startup sequence as seen from the count
    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_PULSE = 2'd1,
        PH_AFTER = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

endpackage

// File: rtl/lockgate_counter.sv
module lockgate_counter #(
    parameter int unsigned CNT_W = lockgate_pkg::DEF_CNT_W,
    parameter int unsigned STOP  = lockgate_pkg::DEF_STOP
) (
    input  logic             clk_i,
    input  logic             lock_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sat_o
);

    localparam logic [CNT_W-1:0] STOP_C = CNT_W'(STOP);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             live;   // set after the first edge; gates checks only
    } cnt_state_t;

    cnt_state_t st_d;
    cnt_state_t st_q = '0;        // configuration-time value

    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        if (lock_i && (st_q.cnt < STOP_C)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign sat_o   = (st_q.cnt == STOP_C);

    AST_STEP_ON_LOCK: assert property (@(posedge clk_i) disable iff (!st_q.live)
        (lock_i && !sat_o) |=> (count_o == $past(count_o) + 1'b1)); // R1
    AST_HOLD_NO_LOCK: assert property (@(posedge clk_i) disable iff (!st_q.live)
        !lock_i |=> $stable(count_o)); // R6
    AST_STAY_SAT: assert property (@(posedge clk_i) disable iff (!st_q.live)
        sat_o |=> sat_o); // R2
    always_comb begin
        AST_NO_OVERRUN: assert (count_o <= STOP_C); // R2
    end

endmodule

// File: rtl/lockgate_window.sv
module lockgate_window #(
    parameter int unsigned CNT_W  = lockgate_pkg::DEF_CNT_W,
    parameter int unsigned WIN_LO = lockgate_pkg::DEF_WIN_LO,
    parameter int unsigned WIN_HI = lockgate_pkg::DEF_WIN_HI
) (
    input  logic                 clk_i,
    input  logic [CNT_W-1:0]     count_i,
    input  logic                 sat_i,
    output lockgate_pkg::phase_e phase_o,
    output logic                 pulse_o
);
    import lockgate_pkg::*;

    localparam logic [CNT_W-1:0] LO_C = CNT_W'(WIN_LO);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(WIN_HI);

    always_comb begin
        if (sat_i) begin
            phase_o = PH_DONE;
        end else if (count_i >= HI_C) begin
            phase_o = PH_AFTER;
        end else if (count_i > LO_C) begin
            phase_o = PH_PULSE;
        end else begin
            phase_o = PH_WAIT;
        end
    end

    assign pulse_o = (phase_o == PH_PULSE);

    AST_PULSE_BELOW_STOP: assert property (@(posedge clk_i)
        pulse_o |-> !sat_i); // R2

endmodule

// File: rtl/lockgate_rst_pulse.sv
module lockgate_rst_pulse #(
    parameter int unsigned CNT_W  = lockgate_pkg::DEF_CNT_W,
    parameter int unsigned WIN_LO = lockgate_pkg::DEF_WIN_LO,
    parameter int unsigned WIN_HI = lockgate_pkg::DEF_WIN_HI,
    parameter int unsigned STOP   = lockgate_pkg::DEF_STOP
) (
    input  logic clk_i,
    input  logic lock_i,
    output logic core_rst_o,
    output logic core_rst_n_o
);
    import lockgate_pkg::*;

    logic [CNT_W-1:0] count_w;
    logic             sat_w;
    phase_e           phase_w;
    logic             pulse_w;
    logic             armed_q = 1'b0;   // gates checks only

    lockgate_counter #(
        .CNT_W (CNT_W),
        .STOP  (STOP)
    ) u_count (
        .clk_i   (clk_i),
        .lock_i  (lock_i),
        .count_o (count_w),
        .sat_o   (sat_w)
    );

    lockgate_window #(
        .CNT_W  (CNT_W),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) u_win (
        .clk_i   (clk_i),
        .count_i (count_w),
        .sat_i   (sat_w),
        .phase_o (phase_w),
        .pulse_o (pulse_w)
    );

    always_ff @(posedge clk_i) begin
        armed_q <= 1'b1;
    end

    assign core_rst_o   = pulse_w;
    assign core_rst_n_o = ~pulse_w;

    AST_RISE_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!armed_q)
        $rose(core_rst_o) |-> $past(lock_i)); // R1
    AST_FALL_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!armed_q)
        $fell(core_rst_o) |-> $past(lock_i)); // R6
    AST_NO_PULSE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!armed_q)
        (phase_w == PH_DONE) |=> !core_rst_o); // R2
    always_comb begin
        AST_POLARITY_PAIR: assert (core_rst_o != core_rst_n_o); // R4
    end

endmodule

// File: tb/sim_lockgate_rst_pulse.sv
`timescale 1ns/100ps
module sim_lockgate_rst_pulse;

    localparam int unsigned LO   = 80;
    localparam int unsigned HI   = 100;
    localparam int unsigned STOP = 120;

    logic clk  = 1'b0;
    logic lock = 1'b0;
    logic rst, rst_n;

    int total = 0;
    int bad   = 0;
    int model = 0;   // independent count of locked edges
    bit ended = 0;

    always #2.5 clk = ~clk;

    lockgate_rst_pulse #(.CNT_W(24), .WIN_LO(LO), .WIN_HI(HI), .STOP(STOP)) u0 (
        .clk_i        (clk),
        .lock_i       (lock),
        .core_rst_o   (rst),
        .core_rst_n_o (rst_n)
    );

    always @(posedge clk) if (lock && model < STOP) model <= model + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // One negedge: compare both outputs with the model, then apply next lock
    task automatic step(input bit nxt_lock, input string req);
        bit exp;
        @(negedge clk);
        exp = (model > LO) && (model < HI);
        check(rst == exp, req, rst, exp);
        check(rst_n == !rst, "R4", rst_n, !rst);
        lock = nxt_lock;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check(rst == 1'b0, "R7", rst, 0);
        check(rst_n == 1'b1, "R7", rst_n, 1);
    endtask

    task automatic t_never_locked;
        for (int i = 0; i < 200; i++) begin
            step(1'b0, "R5");
            check(rst == 1'b0, "R5", rst, 0);
        end
    endtask

    task automatic t_drop_before_window;
        int seen;
        for (int i = 0; i < 40; i++) step(1'b1, "R1");
        for (int i = 0; i < 30; i++) step(1'b0, "R6");
        seen = model;
        check(seen == 40, "R6", seen, 40);
    endtask

    task automatic t_pulse_position_and_gap;
        int edges, locked_hi, held_hi;
        edges = 40;
        lock = 1'b1;
        while (rst == 1'b0 && edges < 400) begin
            @(negedge clk);
            if (rst == 1'b0) edges++;
        end
        check(edges + 1 == LO + 1, "R1", edges + 1, LO + 1);
        locked_hi = 1;
        for (int i = 0; i < 9; i++) begin step(1'b1, "R3"); locked_hi++; end
        lock = 1'b0;
        held_hi = 0;
        for (int i = 0; i < 10; i++) begin
            step(1'b0, "R6");
            if (rst) held_hi++;
        end
        check(held_hi == 10, "R6", held_hi, 10);
        lock = 1'b1;
        while (rst == 1'b1 && locked_hi < 100) begin
            @(negedge clk);
            if (rst) locked_hi++;
        end
        check(locked_hi == HI - LO - 1, "R3", locked_hi, HI - LO - 1);
    endtask

    task automatic t_after_stop;
        for (int i = 0; i < 150; i++) step(1'b1, "R2");
        check(model == STOP, "R2", model, STOP);
        for (int i = 0; i < 200; i++) begin
            step(i[2], "R2");
            check(rst == 1'b0, "R2", rst, 0);
        end
    endtask

    initial begin
        t_reset_state();
        t_never_locked();
        t_drop_before_window();
        t_pulse_position_and_gap();
        t_after_stop();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule